// File: doc/BRIEF.md
# Serial Control-Register Write Port

This block is the configuration port of an audio processing chip. It listens on a two-wire I2C bus as a write-only slave and fills a bank of ten 8-bit control registers. The registers drive the analog side of the chip, which is not part of this block. Both bus lines are sampled on the system clock through two-flop synchronizers. START, STOP and the clock edges are found from the sampled levels.

A transfer begins with a START and an address byte. The chip answers to a write address whose bit 1 comes from a strap input. Next comes a control byte. Its low nibble picks a register index and its top bit picks the write mode. Any number of data bytes may follow. In fixed mode every data byte lands in the same register. In stepping mode the index advances after each byte, and data for indices 10 to 15 is dropped. The slave pulls SDA low through an output enable during every acknowledge clock. It counts clocks and never waits for the master, so a master that skips the acknowledge check works unchanged.

The controller has eight states. ST_IDLE waits for a START. ST_ADDR takes the address byte and moves to ST_ADDR_ACK on a match or to ST_SKIP on a mismatch. ST_ADDR_ACK goes to ST_SUB after the acknowledge clock. ST_SUB takes the control byte and moves to ST_SUB_ACK, which then goes to ST_DATA. ST_DATA takes a data byte and moves to ST_DATA_ACK, which goes back to ST_DATA. ST_SKIP holds until the bus frames again. A START from any state moves to ST_ADDR, and a STOP from any state moves to ST_IDLE.

Top module: `ctlbus_slave`

## Requirements
- R1: After reset the registers hold, for index 0 to 9: 0x3F, 0x1E, 0x00, 0x07, 0x77, 0x60, 0x60, 0x60, 0x60, 0x03. ctl_regs bits [8*i+7:8*i] carry register i.
- R2: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. A START in any state, including a repeated START in the middle of a byte, restarts address reception. After a STOP, bytes are neither acknowledged nor written until the next START.
- R3: The address byte 0x80 is acknowledged when addr_sel is 0, and 0x82 when addr_sel is 1. Bytes are received MSB first.
- R4: Any other address byte gets no acknowledge, including one with bit 0 set (read). The bytes that follow it, up to the next START or STOP, are neither acknowledged nor written.
- R5: Bits 3:0 of the control byte select the register index. Bits 6:4 have no effect.
- R6: When control-byte bit 7 is 0, every data byte up to the STOP is written to the selected register, so the last byte wins.
- R7: When control-byte bit 7 is 1, the index advances by one after each data byte and wraps from 15 to 0. Data for indices 10 to 15 is discarded.
- R8: A data byte is committed on the 8th rising SCL edge. It is kept if a START or STOP follows. A byte cut short by a START or STOP writes nothing.
- R9: sda_oe is 1 from the falling SCL edge after bit 8 to the falling SCL edge after the acknowledge clock. It is 0 at all other times and changes only while SCL is low. Every byte of an addressed transfer is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel | input | 1 | Strap that sets bit 1 of the chip address |
| sda_oe | output | 1 | When 1, pull SDA low (acknowledge) |
| ctl_regs | output | 80 | Ten control registers, index 0 in bits 7:0 |

## Verification
The hardest case to reach from the ports is an abort that lands after one byte has been committed but before the next byte is complete. Reaching it needs a START or STOP at an exact bit position, after the index has already advanced. The bench sends whole bytes and then a chosen number of leading bits of the next byte before framing the bus again. This shows that the earlier write stays, the partial byte writes nothing, and a new transfer right after the repeated START is taken. Stepping bursts that run past index 15 exercise the wrap and the dropped indices.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int NREG_DEF = 10;
    localparam int IDX_W    = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } bus_state_t;

    // Power-up contents of each control register
    function automatic logic [7:0] reg_default(input int idx);
        logic [7:0] v;
        case (idx)
            0:       v = 8'h3F;  // input attenuation max, rear path on
            1:       v = 8'h1E;  // surround off, fixed output, effect max
            2:       v = 8'h00;
            3:       v = 8'h07;
            4:       v = 8'h77;
            5, 6, 7, 8: v = 8'h60;  // attenuators muted
            9:       v = 8'h03;  // input 1 selected
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/ctl_cond.sv
module ctl_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_c,
    output logic stop_c,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;

endmodule

// File: rtl/ctl_fsm.sv
module ctl_fsm
    import ctl_pkg::*;
#(
    parameter logic [7:0] BASE_ADDR = 8'h80,
    parameter int         IW        = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_c,
    input  logic          stop_c,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_bit,
    input  logic          addr_sel,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [7:0]    wr_data
);

    localparam int BITS = 8;
    localparam int CW   = $clog2(BITS);

    bus_state_t    state, state_n;
    logic [7:0]    sh;
    logic [CW-1:0] cnt;
    logic          drv;
    logic [IW-1:0] ptr;
    logic          step;

    logic       byte_last;
    logic [7:0] full_byte;
    logic [7:0] my_addr;
    logic       addr_hit;
    logic       in_rx;
    logic       in_ack;

    assign full_byte = {sh[6:0], sda_bit};
    assign byte_last = scl_rise && (cnt == CW'(BITS - 1));
    assign my_addr   = BASE_ADDR | {6'b0, addr_sel, 1'b0};
    assign addr_hit  = (full_byte == my_addr);
    assign in_rx     = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);
    assign in_ack    = (state == ST_ADDR_ACK) || (state == ST_SUB_ACK) || (state == ST_DATA_ACK);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state;
        if (start_c) begin
            state_n = ST_ADDR;
        end else if (stop_c) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_n = ST_IDLE;
                ST_ADDR:     if (byte_last) state_n = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall && drv) state_n = ST_SUB;
                ST_SUB:      if (byte_last) state_n = ST_SUB_ACK;
                ST_SUB_ACK:  if (scl_fall && drv) state_n = ST_DATA;
                ST_DATA:     if (byte_last) state_n = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall && drv) state_n = ST_DATA;
                ST_SKIP:     state_n = ST_SKIP;
            endcase
        end
    end

    // Shift register, bit counter, ack phase, register pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            cnt  <= '0;
            drv  <= 1'b0;
            ptr  <= '0;
            step <= 1'b0;
        end else if (start_c || stop_c) begin
            cnt <= '0;
            drv <= 1'b0;
        end else begin
            if (in_rx && scl_rise) begin
                sh  <= full_byte;
                cnt <= cnt + 1'b1;
            end
            if (in_ack && scl_fall) begin
                drv <= ~drv;
            end
            if ((state == ST_SUB) && byte_last) begin
                ptr  <= full_byte[IW-1:0];
                step <= full_byte[7];
            end
            if ((state == ST_DATA) && byte_last && step) begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        sda_oe  = in_ack && drv;
        wr_en   = (state == ST_DATA) && byte_last && !start_c && !stop_c;
        wr_idx  = ptr;
        wr_data = full_byte;
    end

endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
    import ctl_pkg::*;
#(
    parameter int NREG = NREG_DEF,
    parameter int IW   = IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [7:0]        wr_data,
    output logic [NREG*8-1:0] regs_flat
);

    logic [7:0] q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[i] <= reg_default(i);
            else if (wr_en && (wr_idx == IW'(i)))
                q[i] <= wr_data;
        end
        assign regs_flat[i*8 +: 8] = q[i];
    end

endmodule

// File: rtl/ctlbus_slave.sv
module ctlbus_slave
    import ctl_pkg::*;
#(
    parameter int         NREG      = NREG_DEF,
    parameter logic [7:0] BASE_ADDR = 8'h80,
    parameter int         SYNC_LEN  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel,
    output logic              sda_oe,
    output logic [NREG*8-1:0] ctl_regs
);

    localparam int IW = IDX_W;

    logic [1:0]    bus_s;
    logic          scl_s, sda_s;
    logic          start_c, stop_c, scl_rise, scl_fall;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [7:0]    wr_data;

    ctl_sync #(.W(2), .STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (bus_s)
    );

    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    ctl_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .start_c  (start_c),
        .stop_c   (stop_c),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    ctl_fsm #(.BASE_ADDR(BASE_ADDR), .IW(IW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_c  (start_c),
        .stop_c   (stop_c),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_bit  (sda_s),
        .addr_sel (addr_sel),
        .sda_oe   (sda_oe),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );

    ctl_regfile #(.NREG(NREG), .IW(IW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .regs_flat (ctl_regs)
    );

endmodule

// File: rtl/ctlbus_slave_chk.sv
module ctlbus_slave_chk #(
    parameter int NREG = 10,
    parameter int IW   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              stop_c,
    input logic              sda_oe,
    input logic              wr_en,
    input logic [IW-1:0]     wr_idx,
    input logic [7:0]        wr_data,
    input logic [NREG*8-1:0] ctl_regs
);

    AST_ACK_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_s);  // R9

    AST_NO_ACK_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> !sda_oe);  // R2

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctl_regs));  // R8

    AST_HIGH_IDX_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) >= NREG)) |=> $stable(ctl_regs));  // R7

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) < NREG)) |=>
            (ctl_regs[int'($past(wr_idx))*8 +: 8] == $past(wr_data)));  // R6

    AST_COMMIT_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> scl_s);  // R8

endmodule

bind ctlbus_slave ctlbus_slave_chk #(.NREG(NREG), .IW(IW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .stop_c   (stop_c),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .ctl_regs (ctl_regs)
);

// File: tb/ctlbus_slave_tb.sv
module ctlbus_slave_tb;

    localparam int NREG = 10;
    localparam int Q    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] ctl_regs;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_r [NREG];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    ctlbus_slave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .addr_sel (addr_sel),
        .sda_oe   (sda_oe),
        .ctl_regs (ctl_regs)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREG; i++)
            chk(ctl_regs[i*8 +: 8] == exp_r[i], req, ctl_regs[i*8 +: 8], exp_r[i]);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b1; wait_q(2*Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wait_q(Q);
        scl_m = 1'b1; wait_q(2*Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int k = 7; k > 7 - n; k--) send_bit(b[k]);
    endtask

    // Full byte plus acknowledge clock; master never relies on the ack
    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        send_bits(b, 8);
        sda_m = 1'b1; wait_q(Q);
        chk(sda_oe == exp_ack, req, sda_oe, exp_ack);
        scl_m = 1'b1; wait_q(Q);
        chk(sda_oe == exp_ack, req, sda_oe, exp_ack);
        wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
        chk(sda_oe == 1'b0, "R9 release", sda_oe, 0);
    endtask

    function automatic logic [7:0] dval(input int seed, input int k);
        return 8'((seed * 29) + (k * 53) + 7);
    endfunction

    // Complete transfer with model update
    task automatic txn(input logic [7:0] a, input logic [7:0] sub, input int n,
                       input int seed, input bit hit, input string req);
        logic [3:0] p;
        bus_start();
        send_byte(a, hit, req);
        send_byte(sub, hit, req);
        p = sub[3:0];
        for (int k = 0; k < n; k++) begin
            send_byte(dval(seed, k), hit, req);
            if (hit && (int'(p) < NREG)) exp_r[p] = dval(seed, k);
            if (sub[7]) p = p + 4'd1;
        end
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
        exp_r[0] = 8'h3F; exp_r[1] = 8'h1E; exp_r[2] = 8'h00; exp_r[3] = 8'h07;
        exp_r[4] = 8'h77; exp_r[5] = 8'h60; exp_r[6] = 8'h60; exp_r[7] = 8'h60;
        exp_r[8] = 8'h60; exp_r[9] = 8'h03;
        wait_q(5);
        rst_n = 1'b1;
        wait_q(5);
        check_regs("R1 reset");
        chk(sda_oe == 1'b0, "R1 reset ack", sda_oe, 0);

        // Address sweep for both strap settings (R3, R4)
        for (int s = 0; s < 2; s++) begin
            addr_sel = s[0];
            for (int ai = 0; ai < 6; ai++) begin
                logic [7:0] a;
                bit hit;
                case (ai)
                    0: a = 8'h80; 1: a = 8'h81; 2: a = 8'h82;
                    3: a = 8'h83; 4: a = 8'h90; default: a = 8'h00;
                endcase
                hit = (a == (8'h80 | {6'b0, s[0], 1'b0}));
                txn(a, 8'h05, 2, s * 6 + ai, hit, hit ? "R3 addr" : "R4 addr");
                check_regs(hit ? "R3 write" : "R4 no write");
            end
        end

        // Fixed mode over all sixteen indices, upper bits varied (R5, R6)
        addr_sel = 1'b1;
        for (int idx = 0; idx < 16; idx++) begin
            logic [7:0] sub;
            sub = {1'b0, 3'(idx * 5), 4'(idx)};
            txn(8'h82, sub, 3, 100 + idx, 1'b1, "R6 fixed");
            check_regs("R5 R6 fixed sweep");
        end

        // Stepping bursts crossing dropped indices and the wrap (R7)
        txn(8'h82, 8'hF8, 12, 200, 1'b1, "R7 burst");
        check_regs("R7 burst from 8");
        txn(8'h82, 8'h8D, 22, 300, 1'b1, "R7 burst");
        check_regs("R7 burst wrap");

        // Commit kept across repeated START, partial byte dropped (R8, R2)
        bus_start();
        send_byte(8'h82, 1'b1, "R8 addr");
        send_byte(8'h83, 1'b1, "R8 sub");
        send_byte(8'hC6, 1'b1, "R8 data");
        exp_r[3] = 8'hC6;
        send_bits(8'h5A, 5);
        bus_start();
        check_regs("R8 repeated start");
        send_byte(8'h82, 1'b1, "R2 restart addr");
        send_byte(8'h04, 1'b1, "R2 restart sub");
        send_byte(8'h9B, 1'b1, "R2 restart data");
        exp_r[4] = 8'h9B;
        bus_stop();
        check_regs("R2 restart write");

        // STOP in mid byte writes nothing (R8)
        bus_start();
        send_byte(8'h82, 1'b1, "R8 addr");
        send_byte(8'h06, 1'b1, "R8 sub");
        send_bits(8'hE1, 3);
        scl_m = 1'b0;
        bus_stop();
        check_regs("R8 stop mid byte");

        // Bytes after STOP without START are ignored (R2)
        send_byte(8'h82, 1'b0, "R2 idle");
        send_byte(8'h06, 1'b0, "R2 idle");
        send_byte(8'h11, 1'b0, "R2 idle");
        bus_stop();
        check_regs("R2 idle no write");

        // Mismatch then bytes until STOP stay ignored (R4)
        bus_start();
        send_byte(8'h80, 1'b0, "R4 skip");
        send_byte(8'h07, 1'b0, "R4 skip");
        send_byte(8'h44, 1'b0, "R4 skip");
        bus_stop();
        check_regs("R4 skip no write");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule